// File: doc/BRIEF.md
# Memory-Mapped User IO Controller

This block connects a small word-wide register bus to a board's user interface hardware. On the output side it drives two seven-segment displays, each with a decimal point. It also drives four red LEDs, four green LEDs and four status LEDs. On the input side it samples three push buttons and a four-position DIP switch.

A control register chooses the source of every LED and every display segment, one bit at a time. When a bit is 0, that output follows the value software wrote. When the bit is 1, it follows a matching hardware port, so on-chip logic can show its own state without software. Each display can show raw segment patterns. It can also decode a 4-bit value into a hexadecimal glyph. Its decimal point always has its own path.

The bus is a plain write strobe with a byte address and write data. Read data is combinational from the address. Button and switch levels are synchronized before software sees them.

Top module: `uio_ctrl`

## Requirements
- R1: After reset the control register reads 0x0F000000 and every other register reads 0. All LED and segment outputs are 0. The status LEDs start under hardware control and every other output starts under software control.
- R2: Registers sit at byte offsets 0x00 control, 0x04 left display, 0x08 right display, 0x0C red LEDs, 0x10 green LEDs, 0x14 status LEDs and 0x18 inputs. Reserved bits ignore writes and read as 0: control bits 31:30, display bits 31:9 and bit 7, and LED register bits 31:4.
- R3: Reading an output register returns the value software last wrote, even while that output is under hardware control.
- R4: In the control register a 0 selects the software register and a 1 selects the hardware port, per bit. Bits 27:24 select the status LEDs, bits 23:20 the green LEDs, bits 19:16 the red LEDs, bits 15:8 the left display and bits 7:0 the right display. Each display byte has segment a at its MSB, then b to g, then the decimal point at bit 0. The same order is used on the display ports.
- R5: In raw mode (control bit 29 for the left display, bit 28 for the right, value 0), display register bits 6 to 0 drive segments a to g.
- R6: In hex mode (the mode bit is 1), display register bits 3:0 are decoded to the glyphs 0-9, A, b, C, d, E, F, and bits 6:4 have no effect.
- R7: A display's decimal point follows bit 8 of its register in both modes.
- R8: In the red and green LED registers, bit 0 drives the lowest LED. In the status register, bits 0 to 3 drive A-green, A-red, B-green and B-red. The status port order is {B-red, B-green, A-red, A-green}.
- R9: The input register at 0x18 returns up on bit 6, middle on bit 5, down on bit 4 and the DIP switch on bits 3:0. The inputs pass through two synchronizer flops and one sample flop, so a change shows on reads after three clock edges.
- R10: A write to 0x18 or to any offset above 0x14 changes no state. A read from an unmapped offset returns 0.
- R11: Outputs are registered: a register write or a hardware port change reaches the pins on the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| hw_hex_l | input | 8 | Hardware source for the left display {a..g,dp} |
| hw_hex_r | input | 8 | Hardware source for the right display {a..g,dp} |
| hw_led_red | input | 4 | Hardware source for the red LEDs |
| hw_led_green | input | 4 | Hardware source for the green LEDs |
| hw_stat | input | 4 | Hardware source for the status LEDs {Bred,Bgreen,Ared,Agreen} |
| btn_up | input | 1 | Up button, asynchronous |
| btn_mid | input | 1 | Middle button, asynchronous |
| btn_down | input | 1 | Down button, asynchronous |
| dip_sw | input | 4 | DIP switch, asynchronous |
| hex_l_seg | output | 8 | Left display drive {a..g,dp} |
| hex_r_seg | output | 8 | Right display drive {a..g,dp} |
| led_red | output | 4 | Red LED drive |
| led_green | output | 4 | Green LED drive |
| led_stat | output | 4 | Status LED drive {Bred,Bgreen,Ared,Agreen} |

## Verification
The bench runs all sixteen hex codes with junk in bits 6:4. A decoder that read those bits, or that had a wrong glyph, would show a wrong segment pattern. It mixes hardware and software sources within a single display byte and within an LED group. This catches a swapped field or an inverted select, which would light the wrong segment. It reads back registers whose outputs are under hardware control. A design returning the pin state there would report the hardware value instead of the written one. It also times the input path edge by edge, writes to the read-only and unmapped offsets, and watches one cycle of output latency. This catches a short or long synchronizer, a write to the input register that sticks, and outputs that are combinational instead of registered.

// File: rtl/uio_pkg.sv
package uio_pkg;

    localparam int DATA_W = 32;
    localparam int LED_N  = 4;
    localparam int SEG_N  = 7;
    localparam int DISP_W = SEG_N + 2;  // dp at bit 8, bit 7 unused
    localparam int IN_W   = 3 + LED_N;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_DL   = 8'h04;
    localparam logic [7:0] OFS_DR   = 8'h08;
    localparam logic [7:0] OFS_RED  = 8'h0C;
    localparam logic [7:0] OFS_GRN  = 8'h10;
    localparam logic [7:0] OFS_STAT = 8'h14;
    localparam logic [7:0] OFS_IN   = 8'h18;

    localparam int CTRL_MODE_L = 29;
    localparam int CTRL_MODE_R = 28;
    localparam logic [DATA_W-1:0] CTRL_RST  = 32'h0F00_0000;
    localparam logic [DATA_W-1:0] CTRL_MASK = 32'h3FFF_FFFF;
    localparam logic [DISP_W-1:0] DISP_MASK = 9'h17F;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DISP_W-1:0] disp_l;
        logic [DISP_W-1:0] disp_r;
        logic [LED_N-1:0]  red;
        logic [LED_N-1:0]  green;
        logic [LED_N-1:0]  stat;
    } uio_regs_t;

    typedef struct packed {
        logic             up;
        logic             mid;
        logic             down;
        logic [LED_N-1:0] dip;
    } uio_in_t;

    // segment pattern {a,b,c,d,e,f,g} for a hex digit
    function automatic logic [SEG_N-1:0] hex_glyph(input logic [3:0] v);
        logic [SEG_N-1:0] g;
        case (v)
            4'h0: g = 7'h7E;  4'h1: g = 7'h30;  4'h2: g = 7'h6D;  4'h3: g = 7'h79;
            4'h4: g = 7'h33;  4'h5: g = 7'h5B;  4'h6: g = 7'h5F;  4'h7: g = 7'h70;
            4'h8: g = 7'h7F;  4'h9: g = 7'h7B;  4'hA: g = 7'h77;  4'hB: g = 7'h1F;
            4'hC: g = 7'h4E;  4'hD: g = 7'h3D;  4'hE: g = 7'h4F;  default: g = 7'h47;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/uio_sync.sv
module uio_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            q    <= '0;
        end else begin
            s1_q <= d;
            q    <= s1_q;
        end
    end
endmodule

// File: rtl/uio_regbank.sv
module uio_regbank
    import uio_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  uio_in_t           in_sync,
    output uio_regs_t         regs,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_DL   = ADDR_W'(OFS_DL);
    localparam logic [ADDR_W-1:0] A_DR   = ADDR_W'(OFS_DR);
    localparam logic [ADDR_W-1:0] A_RED  = ADDR_W'(OFS_RED);
    localparam logic [ADDR_W-1:0] A_GRN  = ADDR_W'(OFS_GRN);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(OFS_IN);

    uio_in_t in_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs      <= '0;
            regs.ctrl <= CTRL_RST;
            in_q      <= '0;
        end else begin
            in_q <= in_sync;
            if (wr_en) begin
                case (addr)
                    A_CTRL: regs.ctrl   <= wdata & CTRL_MASK;
                    A_DL:   regs.disp_l <= wdata[DISP_W-1:0] & DISP_MASK;
                    A_DR:   regs.disp_r <= wdata[DISP_W-1:0] & DISP_MASK;
                    A_RED:  regs.red    <= wdata[LED_N-1:0];
                    A_GRN:  regs.green  <= wdata[LED_N-1:0];
                    A_STAT: regs.stat   <= wdata[LED_N-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (addr)
            A_CTRL:  rdata = regs.ctrl;
            A_DL:    rdata = DATA_W'(regs.disp_l);
            A_DR:    rdata = DATA_W'(regs.disp_r);
            A_RED:   rdata = DATA_W'(regs.red);
            A_GRN:   rdata = DATA_W'(regs.green);
            A_STAT:  rdata = DATA_W'(regs.stat);
            A_IN:    rdata = DATA_W'(in_q);
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/uio_bitmux.sv
module uio_bitmux #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sel,
    input  logic [W-1:0] sw,
    input  logic [W-1:0] hw,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) q[i] <= 1'b0;
            else     q[i] <= sel[i] ? hw[i] : sw[i];
        end
    end
endmodule

// File: rtl/uio_disp_drv.sv
module uio_disp_drv
    import uio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DISP_W-1:0] raw,
    input  logic              hex_mode,
    input  logic [SEG_N:0]    sel,
    input  logic [SEG_N:0]    hw,
    output logic [SEG_N:0]    seg
);
    logic [SEG_N-1:0] body;
    logic [SEG_N:0]   sw_word;

    always_comb begin
        body    = hex_mode ? hex_glyph(raw[3:0]) : raw[SEG_N-1:0];
        sw_word = {body, raw[DISP_W-1]};
    end

    uio_bitmux #(.W(SEG_N + 1)) mux_i (
        .clk(clk), .rst(rst), .sel(sel), .sw(sw_word), .hw(hw), .q(seg)
    );
endmodule

// File: rtl/uio_ctrl.sv
module uio_ctrl
    import uio_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [SEG_N:0]    hw_hex_l,
    input  logic [SEG_N:0]    hw_hex_r,
    input  logic [LED_N-1:0]  hw_led_red,
    input  logic [LED_N-1:0]  hw_led_green,
    input  logic [LED_N-1:0]  hw_stat,
    input  logic              btn_up,
    input  logic              btn_mid,
    input  logic              btn_down,
    input  logic [LED_N-1:0]  dip_sw,
    output logic [SEG_N:0]    hex_l_seg,
    output logic [SEG_N:0]    hex_r_seg,
    output logic [LED_N-1:0]  led_red,
    output logic [LED_N-1:0]  led_green,
    output logic [LED_N-1:0]  led_stat
);
    uio_regs_t regs_q;
    uio_in_t   in_raw;
    uio_in_t   in_sync;

    assign in_raw = '{up: btn_up, mid: btn_mid, down: btn_down, dip: dip_sw};

    uio_sync #(.W(IN_W)) sync_i (
        .clk(clk), .rst(rst), .d(in_raw), .q(in_sync)
    );

    uio_regbank #(.ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst(rst), .addr(bus_addr), .wr_en(bus_wr_en),
        .wdata(bus_wdata), .in_sync(in_sync), .regs(regs_q), .rdata(bus_rdata)
    );

    uio_disp_drv disp_l_i (
        .clk(clk), .rst(rst), .raw(regs_q.disp_l), .hex_mode(regs_q.ctrl[CTRL_MODE_L]),
        .sel(regs_q.ctrl[15:8]), .hw(hw_hex_l), .seg(hex_l_seg)
    );

    uio_disp_drv disp_r_i (
        .clk(clk), .rst(rst), .raw(regs_q.disp_r), .hex_mode(regs_q.ctrl[CTRL_MODE_R]),
        .sel(regs_q.ctrl[7:0]), .hw(hw_hex_r), .seg(hex_r_seg)
    );

    uio_bitmux #(.W(LED_N)) red_i (
        .clk(clk), .rst(rst), .sel(regs_q.ctrl[19:16]), .sw(regs_q.red),
        .hw(hw_led_red), .q(led_red)
    );

    uio_bitmux #(.W(LED_N)) green_i (
        .clk(clk), .rst(rst), .sel(regs_q.ctrl[23:20]), .sw(regs_q.green),
        .hw(hw_led_green), .q(led_green)
    );

    uio_bitmux #(.W(LED_N)) stat_i (
        .clk(clk), .rst(rst), .sel(regs_q.ctrl[27:24]), .sw(regs_q.stat),
        .hw(hw_stat), .q(led_stat)
    );
endmodule

// File: rtl/uio_ctrl_chk.sv
module uio_ctrl_chk
    import uio_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr_en,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [LED_N-1:0]  hw_stat,
    input logic              btn_up,
    input logic              btn_mid,
    input logic              btn_down,
    input logic [LED_N-1:0]  dip_sw,
    input logic [SEG_N:0]    hex_l_seg,
    input logic [LED_N-1:0]  led_red,
    input logic [LED_N-1:0]  led_stat,
    input uio_regs_t         regs_q
);
    logic [2:0] cyc_q;

    always_ff @(posedge clk) begin
        if (rst)              cyc_q <= '0;
        else if (cyc_q != 3'd4) cyc_q <= cyc_q + 3'd1;
    end

    // R1
    ctrl_rst_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_q == 3'd0) |-> (regs_q.ctrl == CTRL_RST && led_red == '0));

    // R2
    ctrl_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(OFS_CTRL)) |-> (bus_rdata[31:30] == 2'b00));

    // R4
    stat_src_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_q >= 3'd1) |-> (led_stat ==
            (($past(hw_stat) & $past(regs_q.ctrl[27:24])) |
             ($past(regs_q.stat) & ~$past(regs_q.ctrl[27:24])))));

    // R7
    dp_direct_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_q >= 3'd1 && !$past(regs_q.ctrl[8])) |-> (hex_l_seg[0] == $past(regs_q.disp_l[DISP_W-1])));

    // R9
    in_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_q >= 3'd3 && bus_addr == ADDR_W'(OFS_IN)) |->
            (bus_rdata[IN_W-1:0] == $past({btn_up, btn_mid, btn_down, dip_sw}, 3)));

    // R10
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && bus_addr > ADDR_W'(OFS_STAT)) |=> $stable(regs_q));
endmodule

bind uio_ctrl uio_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_rdata(bus_rdata), .hw_stat(hw_stat), .btn_up(btn_up), .btn_mid(btn_mid),
    .btn_down(btn_down), .dip_sw(dip_sw), .hex_l_seg(hex_l_seg), .led_red(led_red),
    .led_stat(led_stat), .regs_q(regs_q)
);

// File: tb/uio_ctrl_tb.sv
`timescale 1ns/1ps
module uio_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  hw_hex_l = '0, hw_hex_r = '0;
    logic [3:0]  hw_led_red = '0, hw_led_green = '0, hw_stat = '0;
    logic        btn_up = 1'b0, btn_mid = 1'b0, btn_down = 1'b0;
    logic [3:0]  dip_sw = '0;
    logic [7:0]  hex_l_seg, hex_r_seg;
    logic [3:0]  led_red, led_green, led_stat;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    uio_ctrl #(.ADDR_W(8)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_hex_l(hw_hex_l),
        .hw_hex_r(hw_hex_r), .hw_led_red(hw_led_red), .hw_led_green(hw_led_green),
        .hw_stat(hw_stat), .btn_up(btn_up), .btn_mid(btn_mid), .btn_down(btn_down),
        .dip_sw(dip_sw), .hex_l_seg(hex_l_seg), .hex_r_seg(hex_r_seg),
        .led_red(led_red), .led_green(led_green), .led_stat(led_stat)
    );

    // {hex input nibble, expected {a..g}}
    localparam logic [10:0] HEX_VEC [16] = '{
        {4'h0, 7'h7E}, {4'h1, 7'h30}, {4'h2, 7'h6D}, {4'h3, 7'h79},
        {4'h4, 7'h33}, {4'h5, 7'h5B}, {4'h6, 7'h5F}, {4'h7, 7'h70},
        {4'h8, 7'h7F}, {4'h9, 7'h7B}, {4'hA, 7'h77}, {4'hB, 7'h1F},
        {4'hC, 7'h4E}, {4'hD, 7'h3D}, {4'hE, 7'h4F}, {4'hF, 7'h47}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, v); check("R1 ctrl reset", v, 32'h0F00_0000);
        rd(8'h04, v); check("R1 left reset", v, 32'h0);
        rd(8'h14, v); check("R1 status reset", v, 32'h0);
        check("R1 outputs reset", {hex_l_seg, hex_r_seg, led_red, led_green, led_stat}, 32'h0);

        // R2 reserved bits
        wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v); check("R2 display reserved", v, 32'h17F);
        wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, v); check("R2 led reserved", v, 32'hF);
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); check("R2 ctrl reserved", v, 32'h3FFF_FFFF);
        wr(8'h00, 32'h0);         rd(8'h00, v); check("R2 ctrl clear", v, 32'h0);

        // R5 raw mode with R7 decimal point
        wr(8'h04, 32'h155);
        @(negedge clk);
        check("R5 raw segments", hex_l_seg, 8'hAB);

        // R6 hex decode table with junk in bits 6:4, R7 dp in hex mode
        wr(8'h00, 32'h3000_0000);
        for (int i = 0; i < 16; i++) begin
            wr(8'h08, {25'b0, 3'b101, HEX_VEC[i][10:7]});
            wr(8'h04, {23'b0, 1'b1, 1'b0, 3'b011, HEX_VEC[i][10:7]});
            @(negedge clk);
            check("R6 hex right", hex_r_seg, {HEX_VEC[i][6:0], 1'b0});
            check("R7 hex left dp", hex_l_seg, {HEX_VEC[i][6:0], 1'b1});
        end

        // R8 LED bit mapping under software control
        wr(8'h00, 32'h0);
        wr(8'h0C, 32'h5);
        wr(8'h10, 32'hA);
        wr(8'h14, 32'h3);
        @(negedge clk);
        check("R8 red", led_red, 4'h5);
        check("R8 green", led_green, 4'hA);
        check("R8 status", led_stat, 4'h3);

        // R4 mixed sources
        hw_led_red = 4'hA; hw_led_green = 4'h5; hw_stat = 4'hC;
        hw_hex_l = 8'h0F; hw_hex_r = 8'h3C;
        wr(8'h04, 32'h17F);
        wr(8'h08, 32'h000);
        wr(8'h00, 32'h0FF0_F00F);
        @(negedge clk);
        check("R4 red sw", led_red, 4'h5);
        check("R4 green hw", led_green, 4'h5);
        check("R4 status hw", led_stat, 4'hC);
        check("R4 left mixed", hex_l_seg, 8'h0F);
        check("R4 right mixed", hex_r_seg, 8'h0C);

        // R11 registered output
        hw_stat = 4'h9;
        #1;
        check("R11 before edge", led_stat, 4'hC);
        @(negedge clk);
        check("R11 after edge", led_stat, 4'h9);

        // R3 readback of software value under hardware control
        rd(8'h10, v); check("R3 green readback", v, 32'hA);
        rd(8'h14, v); check("R3 status readback", v, 32'h3);

        // R9 input path latency and bit order
        @(negedge clk);
        btn_up = 1'b1; btn_down = 1'b1; dip_sw = 4'h6;
        @(negedge clk);
        @(negedge clk);
        rd(8'h18, v); check("R9 two edges", v, 32'h0);
        @(negedge clk);
        rd(8'h18, v); check("R9 three edges", v, 32'h56);

        // R10 ignored writes and unmapped reads
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h18, v); check("R10 input write ignored", v, 32'h56);
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h1C, v); check("R10 unmapped read", v, 32'h0);
        rd(8'h40, v); check("R10 far unmapped read", v, 32'h0);
        rd(8'h00, v); check("R10 ctrl unchanged", v, 32'h0FF0_F00F);
        rd(8'h0C, v); check("R10 red unchanged", v, 32'h5);
        @(negedge clk);
        check("R10 outputs unchanged", {hex_l_seg, hex_r_seg, led_red, led_green, led_stat},
              {8'h0F, 8'h0C, 4'h5, 4'h5, 4'h9});

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule